// File: doc/BRIEF.md
# Triple-Oversampled Edge-Triggered Serial Character Receiver

This block recovers 8-bit asynchronous serial characters from an idle-high line. The line is looked at only on cycles where a sample enable is high; that enable runs at three times the bit rate. Every sample therefore covers one third of a bit cell.

While armed, the first low sample is taken as the leading edge of the start bit. It opens a blind capture of a fixed number of samples. No frame-sync input is used. The samples are collected as two 16-sample words taken back to back, and a word-ready strobe marks the end of each word. Once the record is complete, the character is rebuilt by picking one sample per bit cell, least significant bit first. The block then re-arms itself and waits for the line to be high again before it accepts the next falling edge.

The record is decoded in one step after capture, not bit by bit. No per-bit counter or majority vote is used.

Top module: `uart3x_rx`

## Requirements
- R1: While reset is held and right after it, `charValid`, `wordReady` and `frameErr` are low and `charData` is 0x00.
- R2: When the receiver is armed, the first sample taken as low (line = 0 on a cycle with `sampleEn` = 1) becomes sample 0 of a new capture, with no other trigger input.
- R3: A capture holds 32 consecutive samples, grouped as two 16-sample words with no trigger between them. `wordReady` pulses for one cycle after sample 15 and again after sample 31, so each character gives exactly two pulses.
- R4: Data bit k (k = 0..7) of `charData` equals capture sample 3k+4, and bit 0 is the first bit sent after the start bit.
- R5: `frameErr` is set to the inverse of capture sample 28, the stop-bit position. It is updated together with `charValid` and holds until the next character.
- R6: `charValid` is a single-cycle pulse one clock after the 32nd sample is taken. `charData` holds its value until the next pulse.
- R7: After each capture the receiver accepts no new start until it has seen a high sample. A line that stays low after a character produces no further characters.
- R8: Cycles with `sampleEn` = 0 never take a sample: line activity on those cycles starts no capture and produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Sample enable at three times the bit rate |
| rxLine | input | 1 | Serial input, idle high |
| charValid | output | 1 | One-cycle pulse: new character available |
| charData | output | 8 | Recovered character, held until the next one |
| frameErr | output | 1 | Stop-position sample was low for the current character |
| wordReady | output | 1 | One-cycle pulse when a 16-sample word completes |

## Verification
If the sample counter is wrong, or if bits are picked at the wrong offset, the very next character comes out with wrong bits or a wrong frame flag, and `wordReady` fires at the wrong place. If the arming state is wrong, one of two things shows up within one character time. Either a character appears while the line sits low after a framing error, or a character goes missing because a start was not accepted. A character with a low stop bit followed by a long low line, and enable gaps in the middle of characters, bring out these faults at the next compare.

// File: rtl/uart3x_pkg.sv
package uart3x_pkg;

  typedef enum logic [1:0] {
    ST_REARM   = 2'd0,
    ST_ARMED   = 2'd1,
    ST_CAPTURE = 2'd2,
    ST_DECODE  = 2'd3
  } rxState_t;

  typedef struct packed {
    logic shiftEn;   // take the current line sample into the record
    logic wordDone;  // the sample just taken closes a word
    logic finish;    // record complete: decimate and publish
  } rxStrobe_t;

endpackage

// File: rtl/uart3x_ctrl.sv
module uart3x_ctrl
  import uart3x_pkg::*;
#(
  parameter int CAP_LEN = 32,
  parameter int WORD_W  = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleEn,
  input  logic      rxLine,
  output rxStrobe_t strobe
);

  localparam int CNT_W = $clog2(CAP_LEN);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CAP_LEN - 1);

  rxState_t        state, nextState;
  logic [CNT_W-1:0] sampleCnt;
  logic             wordEnd;

  assign wordEnd = ((32'(sampleCnt) % WORD_W) == (WORD_W - 1));

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_REARM: begin
        if (sampleEn && rxLine) nextState = ST_ARMED;
      end
      ST_ARMED: begin
        if (sampleEn && !rxLine) begin
          strobe.shiftEn = 1'b1;
          nextState      = ST_CAPTURE;
        end
      end
      ST_CAPTURE: begin
        if (sampleEn) begin
          strobe.shiftEn  = 1'b1;
          strobe.wordDone = wordEnd;
          if (sampleCnt == LAST_IDX) nextState = ST_DECODE;
        end
      end
      ST_DECODE: begin
        strobe.finish = 1'b1;
        nextState     = ST_REARM;
      end
      default: nextState = ST_REARM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_REARM;
      sampleCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_ARMED && sampleEn && !rxLine)
        sampleCnt <= CNT_W'(1);
      else if (state == ST_CAPTURE && sampleEn)
        sampleCnt <= sampleCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/uart3x_dp.sv
module uart3x_dp
  import uart3x_pkg::*;
#(
  parameter int CAP_LEN   = 32,
  parameter int OVS       = 3,
  parameter int DATA_BITS = 8,
  parameter int PICK_OFS  = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  rxStrobe_t            strobe,
  output logic                 charValid,
  output logic [DATA_BITS-1:0] charData,
  output logic                 frameErr,
  output logic                 wordReady
);

  // index of the pick inside the stop-bit cell
  localparam int STOP_IDX = OVS * (DATA_BITS + 1) + PICK_OFS;

  logic [CAP_LEN-1:0]   sampleRec;
  logic [DATA_BITS-1:0] picked;

  // record fills from the top; after CAP_LEN shifts bit i is sample i
  always_ff @(posedge clk) begin
    if (!rstN) sampleRec <= '0;
    else if (strobe.shiftEn) sampleRec <= {rxLine, sampleRec[CAP_LEN-1:1]};
  end

  for (genvar k = 0; k < DATA_BITS; k++) begin : g_pick
    assign picked[k] = sampleRec[OVS * (k + 1) + PICK_OFS];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      charValid <= 1'b0;
      charData  <= '0;
      frameErr  <= 1'b0;
      wordReady <= 1'b0;
    end else begin
      wordReady <= strobe.wordDone;
      charValid <= strobe.finish;
      if (strobe.finish) begin
        charData <= picked;
        frameErr <= ~sampleRec[STOP_IDX];
      end
    end
  end

endmodule

// File: rtl/uart3x_rx.sv
module uart3x_rx #(
  parameter int OVS       = 3,
  parameter int DATA_BITS = 8,
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 2,
  parameter int PICK_OFS  = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleEn,
  input  logic                 rxLine,
  output logic                 charValid,
  output logic [DATA_BITS-1:0] charData,
  output logic                 frameErr,
  output logic                 wordReady
);

  localparam int CAP_LEN = WORD_W * NUM_WORDS;

  uart3x_pkg::rxStrobe_t strobe;

  uart3x_ctrl #(
    .CAP_LEN (CAP_LEN),
    .WORD_W  (WORD_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (sampleEn),
    .rxLine   (rxLine),
    .strobe   (strobe)
  );

  uart3x_dp #(
    .CAP_LEN   (CAP_LEN),
    .OVS       (OVS),
    .DATA_BITS (DATA_BITS),
    .PICK_OFS  (PICK_OFS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxLine    (rxLine),
    .strobe    (strobe),
    .charValid (charValid),
    .charData  (charData),
    .frameErr  (frameErr),
    .wordReady (wordReady)
  );

endmodule

// File: rtl/uart3x_rx_chk.sv
module uart3x_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sampleEn,
  input logic                 charValid,
  input logic [DATA_BITS-1:0] charData,
  input logic                 frameErr,
  input logic                 wordReady
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    charValid |=> !charValid);  // R6

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !charValid |-> $stable(charData));  // R6

  AST_FERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !charValid |-> $stable(frameErr));  // R5

  AST_WORD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |=> !wordReady);  // R3

  AST_VALID_AFTER_WORD: assert property (@(posedge clk) disable iff (!rstN)
    charValid |-> $past(wordReady));  // R3

  AST_WORD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |-> $past(sampleEn));  // R8

endmodule

bind uart3x_rx uart3x_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (.*);

// File: tb/uart3x_rx_bench.sv
module uart3x_rx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleEn = 1'b0;
  logic       rxLine = 1'b1;
  logic       charValid;
  logic [7:0] charData;
  logic       frameErr;
  logic       wordReady;

  always #4 clk = ~clk;  // 125 MHz

  uart3x_rx u_uart3x_rx (
    .clk       (clk),
    .rstN      (rstN),
    .sampleEn  (sampleEn),
    .rxLine    (rxLine),
    .charValid (charValid),
    .charData  (charData),
    .frameErr  (frameErr),
    .wordReady (wordReady)
  );

  typedef struct {
    logic [7:0] data;
    logic       ferr;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  int wordCount = 0;
  int charsSent = 0;
  logic [7:0] lastData = 8'h00;
  logic       lastFerr = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one sample period: drive line, enable for one clock, then idle clocks
  task automatic tick(input logic v, input int idle);
    rxLine   = v;
    sampleEn = 1'b1;
    @(negedge clk);
    sampleEn = 1'b0;
    repeat (idle) @(negedge clk);
  endtask

  task automatic sendChar(input logic [7:0] d, input logic stopBit, input int idle,
                          input int gap);
    expItem_t e;
    e.data = d;
    e.ferr = ~stopBit;
    expQ.push_back(e);
    charsSent++;
    for (int s = 0; s < 3; s++) tick(1'b0, idle);
    for (int b = 0; b < 8; b++)
      for (int s = 0; s < 3; s++) tick(d[b], idle);
    for (int s = 0; s < 3; s++) tick(stopBit, idle);
    for (int s = 0; s < gap; s++) tick(stopBit, idle);
    if (stopBit) lastFerr = 1'b0; else lastFerr = 1'b1;
    lastData = d;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (wordReady) wordCount++;
      if (charValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected character", int'(charData), 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(charData == e.data, "R4 data", int'(charData), int'(e.data));
          check(frameErr == e.ferr, "R5 frame flag", int'(frameErr), int'(e.ferr));
        end
      end
    end
  end

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(charValid == 1'b0 && wordReady == 1'b0 && frameErr == 1'b0,
          "R1 flags in reset", {charValid, wordReady, frameErr}, 0);
    check(charData == 8'h00, "R1 data in reset", int'(charData), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(charValid == 1'b0 && charData == 8'h00, "R1 after reset",
          int'(charData), 0);

    // idle high to arm, then characters with varied patterns (R2, R4)
    for (int i = 0; i < 3; i++) tick(1'b1, 1);
    sendChar(8'hA5, 1'b1, 1, 4);
    check(wordCount == 2 * charsSent, "R3 word pulses", wordCount, 2 * charsSent);
    sendChar(8'h00, 1'b1, 0, 4);
    sendChar(8'hFF, 1'b1, 2, 4);
    sendChar(8'h5A, 1'b1, 0, 4);
    sendChar(8'h01, 1'b1, 1, 4);
    sendChar(8'h80, 1'b1, 3, 4);
    check(wordCount == 2 * charsSent, "R3 word pulses", wordCount, 2 * charsSent);

    // R5 + R7: low stop bit, line then stays low for many samples
    sendChar(8'h3C, 1'b0, 1, 12);
    for (int i = 0; i < 4; i++) tick(1'b1, 1);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R7 no spurious start", expQ.size(), 0);
    check(frameErr == 1'b1, "R5 frame flag held", int'(frameErr), 1);
    sendChar(8'hC3, 1'b1, 1, 4);
    check(wordCount == 2 * charsSent, "R3 word pulses", wordCount, 2 * charsSent);

    // R8: line toggles while sampleEn stays low
    for (int i = 0; i < 20; i++) begin
      rxLine = i[0];
      @(negedge clk);
    end
    rxLine = 1'b1;
    repeat (4) @(negedge clk);
    check(charValid == 1'b0 && wordCount == 2 * charsSent,
          "R8 no capture without enable", wordCount, 2 * charsSent);
    check(charData == lastData, "R6 data held", int'(charData), int'(lastData));
    check(frameErr == lastFerr, "R5 flag held", int'(frameErr), int'(lastFerr));
    sendChar(8'h96, 1'b1, 0, 4);
    sendChar(8'h69, 1'b1, 2, 6);
    repeat (10) @(negedge clk);

    check(expQ.size() == 0, "R6 all characters delivered", expQ.size(), 0);
    check(wordCount == 2 * charsSent, "R3 total word pulses", wordCount, 2 * charsSent);
    check(charData == 8'h69, "R6 last data held", int'(charData), 8'h69);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule